// File: doc/BRIEF.md
# Burst-Mode Loop Synchronization Controller

This controller schedules the ping-pong burst timing of a time-compression-multiplexed two-wire link. The same logic serves either end. The master end transmits one burst at the start of every burst period, taken from a local frame counter. That counter may free-run or be restarted by an external frame-sync strobe. The slave end answers each burst it receives: it closes its receiver at the end of that burst, waits a guard interval and then sends its reply.

When the slave starts activation on its own, it sends a wake-up pattern with a burst in every second period only. It keeps that pattern until it accepts its first burst from the far end, and from then on it re-times to the incoming bursts. At both ends a flywheel counts burst windows that hold a valid burst and windows that stay empty, and it sets and clears an in-sync flag with hysteresis. Any change of the in-sync flag or of the line-signal indication produces a single-cycle status-change pulse.

One clock cycle stands for one line symbol period. The line receiver reports the end of each received burst with a strobe and marks whether the burst was correctly formatted.

Top module: `burst_loop_sync`

## Requirements
- R1: While reset is asserted and while `activate` is low, `tx_enable`, `rx_enable` and `in_sync` stay low. Line-signal changes are still tracked (see R9).
- R2: Master (`slave_mode`=0): from the first cycle after `activate` is sampled high, each period of FRAME_LEN cycles opens with BURST_LEN cycles of `tx_enable`. `rx_enable` covers the remaining cycles of the period. The two are never high together.
- R3: Master: a pulse on `ext_sync` sampled while `ext_sync_en`=1 restarts the period, so the next cycle is cycle 0 of a new burst. With `ext_sync_en`=0 the pulse has no effect. The slave never uses it.
- R4: Slave, before any burst has been accepted: `tx_enable` is high during the first BURST_LEN cycles of every second period, starting with the first period. `rx_enable` is high in every other cycle.
- R5: Slave: a burst is accepted when `rx_burst_end` and `rx_burst_ok` are both high in a cycle where `rx_enable` is high. The following GUARD cycles have neither enable. Then come BURST_LEN cycles of `tx_enable`, and `rx_enable` stays high after that until the next acceptance. If FRAME_LEN cycles pass without an acceptance, this schedule repeats.
- R6: A burst-end strobe has no effect if `rx_enable` is low or `rx_burst_ok` is low. It causes no re-timing and does not count as a valid burst.
- R7: Out of sync, ACQ_COUNT consecutive good windows raise `in_sync`. At the master, a good window is a period that held an accepted burst. At the slave, it is an accepted burst.
- R8: In sync, LOSS_COUNT consecutive empty windows clear `in_sync`, and the search starts again. At the master, an empty window is a period without an accepted burst. At the slave, it is FRAME_LEN cycles without an acceptance.
- R9: `status_change` is high for exactly one cycle whenever `in_sync` changes, or whenever the registered copy of `line_detect` (one cycle of delay) changes.
- R10: If `activate` is sampled low, `tx_enable`, `rx_enable` and `in_sync` are low from the next cycle on. Timing and flywheel state restart from zero on the next activation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| slave_mode | input | 1 | 0 = master end, 1 = slave end |
| activate | input | 1 | Power up and run the loop |
| line_detect | input | 1 | Line-signal present indication |
| ext_sync_en | input | 1 | Master: lock the period to `ext_sync` |
| ext_sync | input | 1 | Master: external burst-sync strobe |
| rx_burst_end | input | 1 | Received burst has ended |
| rx_burst_ok | input | 1 | That burst was correctly formatted |
| tx_enable | output | 1 | Transmit a burst now |
| rx_enable | output | 1 | Receiver input open |
| in_sync | output | 1 | Loop synchronization achieved |
| status_change | output | 1 | One-cycle pulse on status change |

## Verification
The hardest situation to reach is the slave moving from its half-rate wake-up pattern into re-timed replies. A far-end burst only counts if it lands inside the slave's receive window, and that window depends on the local phase the slave has already built up. The bench emulates a master peer with its own free-running period that is started at an arbitrary point. Some peer bursts therefore fall into the slave's wake-up transmit slots and must be ignored, while a later one is accepted. A cycle-by-cycle behavioural model follows the same exchange, and a stretch of malformed bursts followed by silence drives the flywheel out of sync again.

// File: rtl/burst_sync_pkg.sv
package burst_sync_pkg;

    typedef enum logic {
        ROLE_MASTER = 1'b0,
        ROLE_SLAVE  = 1'b1
    } loop_role_e;

    // Window verdict handed from the burst timer to the flywheel
    typedef struct packed {
        logic good;
        logic miss;
    } window_evt_t;

    localparam window_evt_t NO_EVENT = '{good: 1'b0, miss: 1'b0};

    function automatic window_evt_t make_evt(input logic closed, input logic hit);
        window_evt_t e;
        e.good = closed & hit;
        e.miss = closed & ~hit;
        return e;
    endfunction

endpackage

// File: rtl/burst_frame_timer.sv
module burst_frame_timer
    import burst_sync_pkg::*;
#(
    parameter int FRAME_LEN = 64,
    parameter int BURST_LEN = 37,
    parameter int GUARD     = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        activate,
    input  loop_role_e  role,
    input  logic        ext_sync_en,
    input  logic        ext_sync,
    input  logic        rx_burst_end,
    input  logic        rx_burst_ok,
    output logic        tx_en,
    output logic        rx_en,
    output window_evt_t evt
);
    localparam int CW = $clog2(FRAME_LEN);
    localparam logic [CW-1:0] LAST     = CW'(FRAME_LEN - 1);
    localparam logic [CW-1:0] TX_END   = CW'(BURST_LEN);
    localparam logic [CW-1:0] RPL_BEG  = CW'(GUARD);
    localparam logic [CW-1:0] RPL_END  = CW'(GUARD + BURST_LEN);

    logic          act_q;
    logic [CW-1:0] cnt;
    logic          odd_period;
    logic          heard;
    logic          seen;

    logic is_slave, cnt_last, wake_tx, reply_tx, accept, restart;

    always_comb begin
        is_slave = (role == ROLE_SLAVE);
        cnt_last = (cnt == LAST);
        wake_tx  = !odd_period && (cnt < TX_END);
        reply_tx = (cnt >= RPL_BEG) && (cnt < RPL_END);
        if (!act_q) begin
            tx_en = 1'b0;
            rx_en = 1'b0;
        end else if (!is_slave) begin
            tx_en = (cnt < TX_END);
            rx_en = (cnt >= TX_END);
        end else if (heard) begin
            tx_en = reply_tx;
            rx_en = (cnt >= RPL_END);
        end else begin
            tx_en = wake_tx;
            rx_en = !wake_tx;
        end
        accept  = rx_burst_end && rx_burst_ok && rx_en;
        restart = !is_slave && ext_sync_en && ext_sync;
        evt     = NO_EVENT;
        if (activate && act_q) begin
            if (is_slave)
                evt = accept ? make_evt(1'b1, 1'b1) : make_evt(cnt_last, 1'b0);
            else if (!restart)
                evt = make_evt(cnt_last, seen || accept);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !activate) begin
            act_q      <= 1'b0;
            cnt        <= '0;
            odd_period <= 1'b0;
            heard      <= 1'b0;
            seen       <= 1'b0;
        end else begin
            act_q <= 1'b1;
            if (act_q) begin
                if (!is_slave) begin
                    if (restart) begin
                        cnt  <= '0;
                        seen <= seen || accept;
                    end else if (cnt_last) begin
                        cnt        <= '0;
                        odd_period <= !odd_period;
                        seen       <= 1'b0;
                    end else begin
                        cnt  <= cnt + 1'b1;
                        seen <= seen || accept;
                    end
                end else begin
                    if (accept) begin
                        cnt        <= '0;
                        odd_period <= 1'b0;
                        heard      <= 1'b1;
                    end else if (cnt_last) begin
                        cnt        <= '0;
                        odd_period <= !odd_period;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end

    assert_tx_rx_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
        !(tx_en && rx_en));

    assert_guard_after_accept_R5: assert property (@(posedge clk) disable iff (rst)
        (accept && is_slave && activate) |=> (!tx_en && !rx_en));

    assert_single_verdict_R7: assert property (@(posedge clk) disable iff (rst)
        !(evt.good && evt.miss));

    assert_ignored_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        (is_slave && activate && act_q && rx_burst_end && !rx_en && !cnt_last)
        |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/sync_flywheel.sv
module sync_flywheel
    import burst_sync_pkg::*;
#(
    parameter int ACQ_COUNT  = 4,
    parameter int LOSS_COUNT = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        activate,
    input  window_evt_t evt,
    output logic        in_sync
);
    localparam int GW = $clog2(ACQ_COUNT + 1);
    localparam int MW = $clog2(LOSS_COUNT + 1);
    localparam logic [GW-1:0] GOOD_TOP = GW'(ACQ_COUNT - 1);
    localparam logic [MW-1:0] MISS_TOP = MW'(LOSS_COUNT - 1);

    logic [GW-1:0] good_run;
    logic [MW-1:0] miss_run;

    always_ff @(posedge clk) begin
        if (rst || !activate) begin
            in_sync  <= 1'b0;
            good_run <= '0;
            miss_run <= '0;
        end else if (!in_sync) begin
            if (evt.good) begin
                if (good_run == GOOD_TOP) begin
                    in_sync  <= 1'b1;
                    good_run <= '0;
                    miss_run <= '0;
                end else begin
                    good_run <= good_run + 1'b1;
                end
            end else if (evt.miss) begin
                good_run <= '0;
            end
        end else begin
            if (evt.miss) begin
                if (miss_run == MISS_TOP) begin
                    in_sync  <= 1'b0;
                    miss_run <= '0;
                    good_run <= '0;
                end else begin
                    miss_run <= miss_run + 1'b1;
                end
            end else if (evt.good) begin
                miss_run <= '0;
            end
        end
    end

    assert_rise_needs_good_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(in_sync) |-> $past(evt.good));

    assert_fall_has_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(in_sync) |-> ($past(evt.miss) || !$past(activate)));

    assert_good_run_bound_R7: assert property (@(posedge clk) disable iff (rst)
        good_run < GW'(ACQ_COUNT));

    assert_miss_run_bound_R8: assert property (@(posedge clk) disable iff (rst)
        miss_run < MW'(LOSS_COUNT));

endmodule

// File: rtl/status_notifier.sv
module status_notifier (
    input  logic clk,
    input  logic rst,
    input  logic line_detect,
    input  logic in_sync,
    output logic status_change
);
    logic ld_q, ld_d, sync_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_q   <= 1'b0;
            ld_d   <= 1'b0;
            sync_d <= 1'b0;
        end else begin
            ld_q   <= line_detect;
            ld_d   <= ld_q;
            sync_d <= in_sync;
        end
    end

    assign status_change = (ld_q ^ ld_d) | (in_sync ^ sync_d);

    assert_pulse_is_single_R9: assert property (@(posedge clk) disable iff (rst)
        (status_change && $stable(line_detect) && $stable(in_sync)) |=> !status_change);

endmodule

// File: rtl/burst_loop_sync.sv
module burst_loop_sync
    import burst_sync_pkg::*;
#(
    parameter int FRAME_LEN  = 64,
    parameter int BURST_LEN  = 37,
    parameter int GUARD      = 6,
    parameter int ACQ_COUNT  = 4,
    parameter int LOSS_COUNT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic slave_mode,
    input  logic activate,
    input  logic line_detect,
    input  logic ext_sync_en,
    input  logic ext_sync,
    input  logic rx_burst_end,
    input  logic rx_burst_ok,
    output logic tx_enable,
    output logic rx_enable,
    output logic in_sync,
    output logic status_change
);
    loop_role_e  role;
    window_evt_t evt;

    assign role = slave_mode ? ROLE_SLAVE : ROLE_MASTER;

    burst_frame_timer #(
        .FRAME_LEN (FRAME_LEN),
        .BURST_LEN (BURST_LEN),
        .GUARD     (GUARD)
    ) u_timer (
        .clk          (clk),
        .rst          (rst),
        .activate     (activate),
        .role         (role),
        .ext_sync_en  (ext_sync_en),
        .ext_sync     (ext_sync),
        .rx_burst_end (rx_burst_end),
        .rx_burst_ok  (rx_burst_ok),
        .tx_en        (tx_enable),
        .rx_en        (rx_enable),
        .evt          (evt)
    );

    sync_flywheel #(
        .ACQ_COUNT  (ACQ_COUNT),
        .LOSS_COUNT (LOSS_COUNT)
    ) u_flywheel (
        .clk      (clk),
        .rst      (rst),
        .activate (activate),
        .evt      (evt),
        .in_sync  (in_sync)
    );

    status_notifier u_status (
        .clk           (clk),
        .rst           (rst),
        .line_detect   (line_detect),
        .in_sync       (in_sync),
        .status_change (status_change)
    );

    assert_deactivate_clears_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(activate) |-> (!tx_enable && !rx_enable && !in_sync));

    assert_sync_change_flagged_R9: assert property (@(posedge clk) disable iff (rst)
        (in_sync != $past(in_sync)) |-> status_change);

endmodule

// File: tb/test_burst_loop_sync.sv
module test_burst_loop_sync;
    localparam int FL = 64, BL = 37, GD = 6, ACQ = 4, LOSS = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic slave_mode = 1'b0, activate = 1'b0, line_detect = 1'b0;
    logic ext_sync_en = 1'b0, ext_sync = 1'b0, rx_burst_end = 1'b0, rx_burst_ok = 1'b0;
    logic tx_enable, rx_enable, in_sync, status_change;

    always #2.5 clk = ~clk;

    burst_loop_sync #(.FRAME_LEN(FL), .BURST_LEN(BL), .GUARD(GD),
                      .ACQ_COUNT(ACQ), .LOSS_COUNT(LOSS)) i_burst_loop_sync (
        .clk(clk), .rst(rst), .slave_mode(slave_mode), .activate(activate),
        .line_detect(line_detect), .ext_sync_en(ext_sync_en), .ext_sync(ext_sync),
        .rx_burst_end(rx_burst_end), .rx_burst_ok(rx_burst_ok),
        .tx_enable(tx_enable), .rx_enable(rx_enable), .in_sync(in_sync),
        .status_change(status_change));

    int checks = 0, fails = 0;
    bit done = 0;
    string tag = "R1";

    // Behavioural reference state
    int  m_cnt = 0, m_good = 0, m_miss = 0;
    bit  m_act = 0, m_odd = 0, m_heard = 0, m_seen = 0, m_sync = 0, m_sync_d = 0;
    bit  m_ld = 0, m_ld_d = 0;

    function automatic bit exp_tx();
        if (!m_act) return 0;
        if (!slave_mode) return m_cnt < BL;
        if (m_heard) return (m_cnt >= GD) && (m_cnt < GD + BL);
        return !m_odd && (m_cnt < BL);
    endfunction

    function automatic bit exp_rx();
        if (!m_act) return 0;
        if (!slave_mode) return m_cnt >= BL;
        if (m_heard) return m_cnt >= GD + BL;
        return !(!m_odd && (m_cnt < BL));
    endfunction

    always @(posedge clk) begin
        bit acc, g, mi, last;
        acc  = rx_burst_end && rx_burst_ok && exp_rx();
        g    = 0;
        mi   = 0;
        last = (m_cnt == FL - 1);
        m_sync_d = m_sync;
        m_ld_d   = m_ld;
        m_ld     = line_detect;
        if (rst) begin
            m_cnt = 0; m_odd = 0; m_heard = 0; m_seen = 0; m_act = 0;
            m_good = 0; m_miss = 0; m_sync = 0; m_sync_d = 0; m_ld = 0; m_ld_d = 0;
        end else if (!activate) begin
            m_cnt = 0; m_odd = 0; m_heard = 0; m_seen = 0; m_act = 0;
            m_good = 0; m_miss = 0; m_sync = 0;
        end else begin
            if (m_act) begin
                if (!slave_mode) begin
                    if (ext_sync_en && ext_sync) begin
                        m_cnt = 0; m_seen = m_seen || acc;
                    end else if (last) begin
                        if (m_seen || acc) g = 1; else mi = 1;
                        m_cnt = 0; m_seen = 0;
                    end else begin
                        m_cnt++; m_seen = m_seen || acc;
                    end
                end else begin
                    if (acc) begin
                        m_cnt = 0; m_odd = 0; m_heard = 1; g = 1;
                    end else if (last) begin
                        m_cnt = 0; m_odd = !m_odd; mi = 1;
                    end else m_cnt++;
                end
            end
            m_act = 1;
            if (!m_sync) begin
                if (g) begin
                    m_good++;
                    if (m_good == ACQ) begin m_sync = 1; m_good = 0; m_miss = 0; end
                end else if (mi) m_good = 0;
            end else begin
                if (mi) begin
                    m_miss++;
                    if (m_miss == LOSS) begin m_sync = 0; m_miss = 0; m_good = 0; end
                end else if (g) m_miss = 0;
            end
        end
    end

    task automatic check_bit(input string what, input string req, input bit got, input bit exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got %0b expected %0b at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        check_bit("tx_enable", tag, tx_enable, exp_tx());
        check_bit("rx_enable", tag, rx_enable, exp_rx());
        check_bit("in_sync", tag, in_sync, m_sync);
        check_bit("status_change R9", tag, status_change, (m_sync != m_sync_d) || (m_ld != m_ld_d));
    endtask

    // Far-end emulation: 0 off, 1 answer a master, 2 act as a master
    int  fe_mode = 0, fe_t = 0, fe_at = 50;
    bit  fe_ok = 1, fe_early = 0;

    task automatic tick();
        @(negedge clk);
        compare_all();
        rx_burst_end = 0;
        rx_burst_ok  = 0;
        ext_sync     = 0;
        if (fe_mode == 1 && (m_cnt == fe_at || (fe_early && m_cnt == 10))) begin
            rx_burst_end = 1; rx_burst_ok = fe_ok;
        end
        if (fe_mode == 2) begin
            fe_t++;
            if (fe_t % FL == 0) begin rx_burst_end = 1; rx_burst_ok = fe_ok; end
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check_bit("tx_enable reset", "R1", tx_enable, 0);
        check_bit("rx_enable reset", "R1", rx_enable, 0);
        check_bit("in_sync reset", "R1", in_sync, 0);
        check_bit("status_change reset", "R1", status_change, 0);
        rst = 0;
        tag = "R1";
        run(10);
        // R1 R9: line detect tracked while inactive
        line_detect = 1;
        tag = "R1 R9";
        run(4);
        line_detect = 0;
        run(4);

        // Master: timing, acquisition with ignored early strobes
        tag = "R2 R6 R7";
        activate = 1;
        fe_mode = 1; fe_ok = 1; fe_early = 1;
        run(7 * FL);
        check_bit("in_sync after good periods", "R7", in_sync, 1);
        // R6 R8: malformed bursts only, sync lost
        tag = "R6 R8";
        fe_ok = 0; fe_early = 0;
        run(6 * FL);
        check_bit("in_sync after empty periods", "R8", in_sync, 0);
        tag = "R7";
        fe_ok = 1;
        run(6 * FL);
        // R3: external restart honoured, then ignored when disabled
        tag = "R3";
        ext_sync_en = 1;
        wait_cnt(20);
        ext_sync = 1;
        tick();
        run(2 * FL);
        ext_sync_en = 0;
        wait_cnt(20);
        ext_sync = 1;
        tick();
        run(FL);
        // R10: deactivate
        tag = "R10 R9";
        activate = 0;
        tick();
        check_bit("tx_enable after deactivate", "R10", tx_enable, 0);
        check_bit("in_sync after deactivate", "R10", in_sync, 0);
        run(10);

        // Slave: wake-up pattern, then peer arrives
        slave_mode = 1;
        fe_mode = 0;
        tag = "R4";
        activate = 1;
        run(5 * FL + 13);
        tag = "R5 R6 R7";
        fe_mode = 2; fe_t = 0; fe_ok = 1;
        run(8 * FL);
        check_bit("slave in_sync", "R7", in_sync, 1);
        tag = "R6 R8";
        fe_ok = 0;
        run(3 * FL);
        fe_mode = 0;
        run(4 * FL);
        check_bit("slave sync lost", "R8", in_sync, 0);
        tag = "R10";
        activate = 0;
        tick();
        check_bit("slave tx after deactivate", "R10", tx_enable, 0);
        check_bit("slave rx after deactivate", "R10", rx_enable, 0);
        run(5);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    task automatic wait_cnt(input int c);
        for (int i = 0; i < 2 * FL; i++) begin
            if (m_cnt == c) break;
            tick();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule